// File: doc/BRIEF.md
# Multiplexed LED Bank Scanner

This block drives five common-cathode LED banks in time division. It holds a 24-bit display word and lights one bank at a time, in the order bank 1 to bank 5, and then starts again at bank 1. Each bank's slot lasts a fixed number of system-clock cycles, set by a parameter, so one full pass runs at about 1 kHz. For the lit bank the block presents that bank's 4-bit value to a downstream segment decoder. It also gives a decimal-point enable picked by a 3-bit code and a drive-enable that a current-source stage can gate. A brightness bit selects either full drive or a 50% pulse pattern.

A new display word arrives on a valid/ready port. The block never applies back-pressure: `in_ready` is always high, and a word is taken on any cycle in which `in_valid` is high. While the display runs, every word taken blanks the display for one slot. A run control input stops scanning and darkens every output. Words can still be taken while the display is stopped.

Top module: `led_bank_scanner`

## Requirements
- R1: `bank_sel` is active-high and never has more than one bit set. Bit k lights bank k+1.
- R2: While the display runs, each bank stays lit for exactly `SLOT_CYCLES` cycles. The banks are lit in the order 1,2,3,4,5,1,...
- R3: When bank k+1 is lit, `nibble` equals word bits [4k+3:4k], so bank 1 takes bits 3:0 and bank 5 takes bits 19:16. `nibble` is 0 whenever no bank is lit.
- R4: Word bits 22:20 hold the decimal-point code. Code 0 gives no decimal point. Codes 1 to 5 select bank 1 to bank 5. Code 6 selects banks 1 and 2. Code 7 selects every bank. `dp_on` is high only while a selected bank is lit.
- R5: When word bit 23 is 1, `drive_en` is high for the whole of each lit slot. When it is 0, `drive_en` is high only on the even cycles of the slot, counting from 0.
- R6: A word taken while running darkens all outputs from the next cycle for `SLOT_CYCLES` cycles. After that the bank that follows the one lit when the word arrived is shown, and the new word is in effect.
- R7: If a word is taken in the last cycle of a slot, the blanking wins over the slot advance. The blank slot comes next, followed by the next bank in order.
- R8: While `run_en` is low, every output is 0 in that same cycle and scanning is held. When `run_en` goes high again, bank 1 lights at once for a full slot.
- R9: Reset clears the stored word to 0, puts the scan at the start of bank 1 and clears any blanking.
- R10: `in_ready` is always high. A word taken while stopped is stored without blanking and is shown when scanning resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = scan, 0 = standby (dark, held) |
| in_valid | input | 1 | New display word offered |
| in_data | input | 24 | Display word: bank values, decimal-point code, brightness |
| in_ready | output | 1 | Always 1; word taken whenever in_valid is high |
| bank_sel | output | 5 | One-hot cathode select, all 0 when dark |
| nibble | output | 4 | Value of the lit bank for the segment decoder |
| dp_on | output | 1 | Decimal-point enable for the lit bank |
| drive_en | output | 1 | Anode drive enable (full or 50% pattern) |

## Verification
Two events can fall in the same cycle: a word arriving and a slot ending. The bench waits until its reference model shows the slot counter at its last count. It then raises `in_valid` for exactly that cycle. The outputs are judged against the model on every following cycle. The required pattern is one dark slot, then the next bank after the one that was lit. A skipped bank, a second blank slot or a slot of the wrong length counts as a mismatch. A load that arrives in the same cycle that `run_en` falls is also driven. It must leave the word stored with no blanking when scanning resumes.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  parameter int NUM_BANKS  = 5;
  parameter int NIB_W      = 4;
  parameter int WORD_W     = 24;
  parameter int DP_LSB     = NUM_BANKS * NIB_W;
  parameter int DP_W       = 3;
  parameter int BRIGHT_BIT = DP_LSB + DP_W;
  parameter int IDX_W      = $clog2(NUM_BANKS);
endpackage

// File: rtl/led_scan_tick.sv
module led_scan_tick #(
  parameter int SLOT_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic slot_end,
  output logic odd_phase
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end  = run && !restart && (cnt_q == LAST);
  assign odd_phase = cnt_q[0];
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             slot_end,
  output logic [IDX_W-1:0] bank_idx,
  output logic             lit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      blank_q <= 1'b0;
    end else if (!run) begin
      idx_q   <= '0;
      blank_q <= 1'b0;
    end else if (load) begin
      blank_q <= 1'b1;
    end else if (slot_end) begin
      blank_q <= 1'b0;
      idx_q   <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign bank_idx = idx_q;
  assign lit      = run && !blank_q;
endmodule

// File: rtl/led_scan_dp.sv
module led_scan_dp
  import led_scan_pkg::*;
(
  input  logic [DP_W-1:0]      code,
  output logic [NUM_BANKS-1:0] mask
);
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign mask[k] = (code == DP_W'(k + 1)) || (code == 3'd7) ||
                     ((code == 3'd6) && (k < 2));
  end
endmodule

// File: rtl/led_bank_scanner.sv
module led_bank_scanner
  import led_scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 40000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_data,
  output logic                 in_ready,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [NIB_W-1:0]     nibble,
  output logic                 dp_on,
  output logic                 drive_en
);
  logic [WORD_W-1:0]    word_q;
  logic                 take;
  logic                 slot_end;
  logic                 odd_phase;
  logic [IDX_W-1:0]     bank_idx;
  logic                 lit;
  logic [NUM_BANKS-1:0] dp_mask;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (take) word_q <= in_data;
  end

  led_scan_tick #(.SLOT_CYCLES(SLOT_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_en), .restart(take),
    .slot_end(slot_end), .odd_phase(odd_phase)
  );

  led_scan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run_en), .load(take),
    .slot_end(slot_end), .bank_idx(bank_idx), .lit(lit)
  );

  led_scan_dp u_dp (
    .code(word_q[DP_LSB +: DP_W]), .mask(dp_mask)
  );

  assign bank_sel = lit ? (NUM_BANKS'(1) << bank_idx) : '0;
  assign nibble   = lit ? word_q[bank_idx * NIB_W +: NIB_W] : '0;
  assign dp_on    = lit && dp_mask[bank_idx];
  assign drive_en = lit && (word_q[BRIGHT_BIT] || !odd_phase);
endmodule

// File: rtl/led_bank_scanner_chk.sv
module led_bank_scanner_chk
  import led_scan_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic [NIB_W-1:0]     nibble,
  input logic                 dp_on,
  input logic                 drive_en
);
  logic [NUM_BANKS-1:0] prev_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_sel <= '0;
    else        prev_sel <= bank_sel;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel)); // R1

  AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sel != '0 && bank_sel != '0 && bank_sel != prev_sel) |->
    (bank_sel == {prev_sel[NUM_BANKS-2:0], prev_sel[NUM_BANKS-1]})); // R2

  AST_NIB_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel == '0) |-> (nibble == '0)); // R3

  AST_DP_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    dp_on |-> (bank_sel != '0)); // R4

  AST_LOAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && in_valid && in_ready) |=> (bank_sel == '0 && !drive_en)); // R6

  AST_STBY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (bank_sel == '0 && !dp_on && !drive_en)); // R8

  AST_RESUME_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !$past(run_en) && !$past(in_valid)) |-> bank_sel[0]); // R8
endmodule

bind led_bank_scanner led_bank_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .in_valid(in_valid),
  .in_ready(in_ready), .bank_sel(bank_sel), .nibble(nibble),
  .dp_on(dp_on), .drive_en(drive_en)
);

// File: tb/led_bank_scanner_tb.sv
`timescale 1ns/1ps
module led_bank_scanner_tb;
  localparam int D = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        run_en = 0;
  logic        in_valid = 0;
  logic [23:0] in_data = '0;
  logic        in_ready;
  logic [4:0]  bank_sel;
  logic [3:0]  nibble;
  logic        dp_on;
  logic        drive_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit armed  = 0;
  string cur_req = "R9";

  // reference model state
  int          m_idx = 0, m_cnt = 0;
  bit          m_blank = 0;
  logic [23:0] m_word = '0;

  always #2.5 clk = ~clk;

  led_bank_scanner #(.SLOT_CYCLES(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .bank_sel(bank_sel),
    .nibble(nibble), .dp_on(dp_on), .drive_en(drive_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_cnt = 0; m_blank = 0; m_word = '0;
    end else begin
      armed = 1;
      if (in_valid) m_word = in_data;
      if (!run_en) begin
        m_idx = 0; m_cnt = 0; m_blank = 0;
      end else if (in_valid) begin
        m_blank = 1; m_cnt = 0;
      end else if (m_cnt == D - 1) begin
        m_cnt = 0; m_blank = 0; m_idx = (m_idx + 1) % 5;
      end else begin
        m_cnt++;
      end
    end
  end

  function automatic bit dp_hit(input int code, input int idx);
    if (code == 7) return 1;
    if (code == 6) return idx < 2;
    if (code == 0) return 0;
    return idx == code - 1;
  endfunction

  task automatic cmp(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s (%s): got %0h expected %0h at %0t", what, cur_req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      bit act;
      act = run_en && !m_blank;
      cmp("R2 bank_sel", bank_sel, act ? (1 << m_idx) : 0);
      cmp("R3 nibble", nibble, act ? ((m_word >> (4 * m_idx)) & 4'hF) : 0);
      cmp("R4 dp_on", dp_on, act && dp_hit(int'(m_word[22:20]), m_idx));
      cmp("R5 drive_en", drive_en, act && (m_word[23] || (m_cnt % 2 == 0)));
      cmp("R10 in_ready", in_ready, 1);
      cmp("R1 onehot", $countones(bank_sel) <= 1, 1);
    end
  end

  function automatic logic [23:0] mk(input bit br, input int dp, input logic [19:0] nb);
    return {br, 3'(dp), nb};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [23:0] w);
    in_valid = 1; in_data = w;
    step(1);
    in_valid = 0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R9";
    step(3);
    rst_n = 1;
    step(2);
    cur_req = "R10";
    load(mk(1, 1, 20'h54321));          // stored while stopped
    step(2);
    run_en = 1;
    cur_req = "R8";
    step(1);
    cur_req = "R2";
    step(2 * 5 * D);
    for (int c = 0; c < 8; c++) begin
      cur_req = "R4";
      load(mk(c[0], c, 20'h9A0F7 ^ (c * 20'h11111)));
      cur_req = "R6";
      step(D + 3);
      cur_req = "R5";
      step(5 * D);
    end
    for (int r = 0; r < 3; r++) begin
      cur_req = "R7";
      do step(1); while (!(m_cnt == D - 1 && !m_blank));
      load(mk(r[0], 7 - r, 20'hFEDCB - r));
      step(3 * D);
    end
    cur_req = "R6";
    step(1);
    load(mk(0, 6, 20'h13579));
    step(1);
    load(mk(1, 2, 20'h2468A));          // load during blanking restarts it
    step(2 * D);
    cur_req = "R8";
    step(D + 1);
    run_en = 0;
    step(D + 2);
    load(mk(0, 3, 20'h0BEEF));
    run_en = 1;
    step(5 * D + 2);
    in_valid = 1; in_data = mk(1, 5, 20'hCAFE1); run_en = 0;
    step(1);
    in_valid = 0;
    step(2);
    run_en = 1;
    step(5 * D);
    cur_req = "R9";
    step(2);
    run_en = 0; rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
    run_en = 1;
    step(5 * D);
    cur_req = "R3";
    load(mk(1, 0, 20'h1248F));
    step(6 * D);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule